// File: doc/BRIEF.md
# Flash Burst Read Bus Controller

This block is the device-side pin interface of a NOR-style flash memory model. Every cycle it turns the control pins (reset, chip enable, output enable, write enable, address valid, bus clock activity) into one bus operation: reset, standby, output disable, write, asynchronous read, synchronous burst read or burst suspend. From that operation it decides whether the 16-bit data bus is driven, what value is driven and what the WAIT pin shows. Words come from a small internal word array that the model loads with a known pattern while reset is held.

Synchronous reads run as bursts. A burst starts on a clock edge where address-valid is low. It then steps through the array, either wrapping inside an aligned group of 4, 8 or 16 words or counting linearly without a length limit. The model's system clock `clk` stands for the bus clock. The `bclk_run` input tells whether the bus clock is toggling in that cycle, and a low value during an active burst means the host has stopped the clock, which suspends the burst. The pins follow a fixed protocol and have no handshake. The only flow control is WAIT, which the block raises for one cycle when a continuous burst has to refetch at a 16-word boundary.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, `dq_oe` and `wait_o` are 0 and any burst is cleared, whatever the other pins are.
- R2: With `rst_n` high and `ce_n` high (standby), `dq_oe` is 0 and a low `we_n` does not change the array.
- R3: With `ce_n` low, `oe_n` high and `we_n` high (output disable), `dq_oe` is 0.
- R4: With `ce_n` low, `oe_n` high and `we_n` low (write), `dq_oe` is 0, and each clock edge stores `dq_i` at `addr`.
- R5: With `ce_n` low, `oe_n` low and `sync_mode` 0 (asynchronous read), `dq_oe` is 1 and `dq_o` shows the word at `addr` in the same cycle.
- R6: After reset, the word at index i is i XOR 0xA500.
- R7: In a synchronous read (`sync_mode` 1, `bclk_run` 1), a clock edge with `adv_n` low and no burst active latches `addr` and `burst_len`. From the next cycle `dq_o` shows the word at the start address. `adv_n` and `addr` are ignored while the burst is active.
- R8: For `burst_len` 00, 01 and 10 the burst delivers 4, 8 or 16 words, one per running clock edge. Its address wraps inside the aligned group of that size (the low 2, 3 or 4 bits increment and the upper bits stay). After the last word the burst ends, and a synchronous read with no active burst drives `dq_o` = 0 with `dq_oe` = 1.
- R9: For `burst_len` 11 the address increments linearly. When the current word sits at offset 15 of an aligned 16-word group, the next running edge raises `wait_o` for exactly one cycle and `dq_o` keeps that word. The edge after that moves on to the next address with `wait_o` low.
- R10: When `bclk_run` is low during an active burst while `ce_n` and `oe_n` stay low (suspend), `dq_oe` stays 1, the address and `dq_o` are held, and the burst resumes from the held word once `bclk_run` returns high.
- R11: Taking `ce_n` or `oe_n` high ends an active burst. A later synchronous read drives 0 until a new `adv_n` low edge starts a burst.
- R12: `wait_o` is 0 in every operation other than a synchronous read or a suspend of an active burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock, one edge per bus clock period |
| rst_n | input | 1 | Device reset pin, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid, active low, starts a burst |
| bclk_run | input | 1 | High when the bus clock toggles in this cycle |
| sync_mode | input | 1 | 1 selects synchronous burst reads, 0 asynchronous reads |
| burst_len | input | 2 | 00=4, 01=8, 10=16 words, 11=continuous |
| addr | input | ADDR_W | Word address |
| dq_i | input | DATA_W | Data bus input side |
| dq_o | output | DATA_W | Data bus output side |
| dq_oe | output | 1 | Data bus drive enable, 0 means high impedance |
| wait_o | output | 1 | WAIT pin, high while a refetch stalls the burst |

## Verification
The assertions assume that `rst_n` is the only reset and that the control pins are steady around each rising clock edge. They also assume that `bclk_run` low only ever stands for a halted bus clock, and that `ADDR_W` is larger than the 4 bits of a refetch group. The bench changes every pin on the falling edge and samples one nanosecond later. Between edges it holds the pins still, and it drops `bclk_run` only after a burst has started, so a low `bclk_run` always lands in a true suspend.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_OUTDIS  = 3'd2,
    OP_WRITE   = 3'd3,
    OP_ARD     = 3'd4,
    OP_SRD     = 3'd5,
    OP_SUSP    = 3'd6
  } bus_op_e;

  typedef enum logic [1:0] {
    BL_4    = 2'b00,
    BL_8    = 2'b01,
    BL_16   = 2'b10,
    BL_CONT = 2'b11
  } blen_e;
endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_bus_pkg::*;
(
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    sync_mode,
  input  logic    bclk_run,
  input  logic    burst_act,
  output bus_op_e op,
  output logic    drive_en,
  output logic    wr_en
);
  // Fixed priority: reset, then chip enable, then output enable, then write enable
  always_comb begin
    if (!rst_n)                    op = OP_RESET;
    else if (ce_n)                 op = OP_STANDBY;
    else if (oe_n)                 op = we_n ? OP_OUTDIS : OP_WRITE;
    else if (!sync_mode)           op = OP_ARD;
    else if (burst_act && !bclk_run) op = OP_SUSP;
    else                           op = OP_SRD;
  end

  assign drive_en = (op == OP_ARD) || (op == OP_SRD) || (op == OP_SUSP);
  assign wr_en    = (op == OP_WRITE);
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter logic [15:0] SEED   = 16'hA500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Contents load from the index pattern while reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= DATA_W'(i) ^ DATA_W'(SEED);
      end
    end else if (wr_en) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int GROUP_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_op_e           op,
  input  logic              bclk_run,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        len_sel,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              stall
);
  localparam int CNT_W = GROUP_LOG;

  logic [ADDR_W-1:0] cur_q;
  logic [CNT_W-1:0]  cnt_q;
  blen_e             len_q;
  logic              act_q;
  logic              stall_q;

  logic              go, start, step, kill;
  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] wrap_next;
  logic [CNT_W-1:0]  last_cnt;
  logic              at_group_end;

  assign go    = (op == OP_SRD) && bclk_run;
  assign start = go && !adv_n && !act_q;
  assign step  = go && act_q;
  assign kill  = (op != OP_SRD) && (op != OP_SUSP);

  // Fixed bursts: group size 4 << len
  always_comb begin
    unique case (len_q)
      BL_4:    begin wrap_mask = ADDR_W'(3);  last_cnt = CNT_W'(3);  end
      BL_8:    begin wrap_mask = ADDR_W'(7);  last_cnt = CNT_W'(7);  end
      default: begin wrap_mask = ADDR_W'(15); last_cnt = CNT_W'(15); end
    endcase
  end

  assign wrap_next    = (cur_q & ~wrap_mask) | ((cur_q + ADDR_W'(1)) & wrap_mask);
  assign at_group_end = &cur_q[GROUP_LOG-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      cnt_q   <= '0;
      len_q   <= BL_4;
      act_q   <= 1'b0;
      stall_q <= 1'b0;
    end else if (kill) begin
      act_q   <= 1'b0;
      stall_q <= 1'b0;
    end else if (start) begin
      act_q   <= 1'b1;
      cur_q   <= start_addr;
      cnt_q   <= '0;
      len_q   <= blen_e'(len_sel);
      stall_q <= 1'b0;
    end else if (step) begin
      if (len_q == BL_CONT) begin
        if (stall_q) begin
          stall_q <= 1'b0;
          cur_q   <= cur_q + ADDR_W'(1);
        end else if (at_group_end) begin
          stall_q <= 1'b1;
        end else begin
          cur_q <= cur_q + ADDR_W'(1);
        end
      end else if (cnt_q == last_cnt) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        cur_q <= wrap_next;
      end
    end
  end

  assign cur_addr = cur_q;
  assign active   = act_q;
  assign stall    = stall_q;

  // R10: a halted bus clock freezes the burst position
  a_r10_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUSP) |=> ($stable(cur_q) && $stable(stall_q) && act_q));

  // R8: fixed bursts never leave their aligned group
  a_r8_wrap_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (step && len_q != BL_CONT) |=>
      (cur_q[ADDR_W-1:GROUP_LOG] == $past(cur_q[ADDR_W-1:GROUP_LOG])));

  // R9: the refetch stall lasts a single running edge
  a_r9_wait_single: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && step) |=> !stall_q);

  // R7: a running burst is not restarted by address-valid
  a_r7_adv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !adv_n && len_q == BL_CONT) |=> (act_q && $stable(len_q)));
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int GROUP_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic              bclk_run,
  input  logic              sync_mode,
  input  logic [1:0]        burst_len,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              wait_o
);
  bus_op_e           op;
  logic              drive_en, wr_en;
  logic              burst_act, burst_stall;
  logic [ADDR_W-1:0] burst_addr, rd_addr;
  logic [DATA_W-1:0] rd_word;

  flash_op_decode u_decode (
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .sync_mode (sync_mode),
    .bclk_run  (bclk_run),
    .burst_act (burst_act),
    .op        (op),
    .drive_en  (drive_en),
    .wr_en     (wr_en)
  );

  flash_burst_seq #(.ADDR_W(ADDR_W), .GROUP_LOG(GROUP_LOG)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .bclk_run   (bclk_run),
    .adv_n      (adv_n),
    .start_addr (addr),
    .len_sel    (burst_len),
    .cur_addr   (burst_addr),
    .active     (burst_act),
    .stall      (burst_stall)
  );

  assign rd_addr = (op == OP_ARD) ? addr : burst_addr;

  flash_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .waddr (addr),
    .wdata (dq_i),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  always_comb begin
    dq_o = '0;
    if (op == OP_ARD || (drive_en && burst_act)) dq_o = rd_word;
  end

  assign dq_oe  = drive_en;
  assign wait_o = burst_stall && burst_act && ((op == OP_SRD) || (op == OP_SUSP));

  // R2: standby floats the bus
  a_r2_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  // R4: a write cycle leaves the bus as an input
  a_r4_write_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !we_n) |-> !dq_oe);

  // R12: WAIT only carries meaning in synchronous reads
  a_r12_wait_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (!ce_n && !oe_n && sync_mode && burst_act));
endmodule

// File: tb/flash_bus_ctrl_tb.sv
module flash_bus_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n, ce_n, oe_n, we_n, adv_n, bclk_run, sync_mode;
  logic [1:0]    burst_len;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe, wait_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .bclk_run(bclk_run), .sync_mode(sync_mode),
    .burst_len(burst_len), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .wait_o(wait_o)
  );

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i) ^ 16'hA500;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic next_cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_pins();
    ce_n = 1; oe_n = 1; we_n = 1; adv_n = 1; bclk_run = 1;
    sync_mode = 0; burst_len = 2'b00; addr = '0; dq_i = '0;
  endtask

  task automatic t_reset();
    idle_pins();
    rst_n = 0; ce_n = 0; oe_n = 0; sync_mode = 1; adv_n = 0;
    next_cyc();
    chk("R1 dq_oe in reset", dq_oe, 0);
    chk("R1 wait in reset", wait_o, 0);
    next_cyc();
    rst_n = 1; ce_n = 1; oe_n = 1; adv_n = 1; sync_mode = 0;
    next_cyc();
  endtask

  task automatic t_async_read();
    ce_n = 0; oe_n = 0; we_n = 1; sync_mode = 0;
    foreach (addr[i]) begin end
    for (int a = 0; a < 256; a += 37) begin
      addr = AW'(a);
      #1;
      chk("R6 R5 async word", dq_o, init_word(a));
      chk("R5 async dq_oe", dq_oe, 1);
      chk("R12 wait async", wait_o, 0);
    end
    next_cyc();
    idle_pins();
  endtask

  task automatic t_write_standby();
    next_cyc();
    ce_n = 0; oe_n = 1; we_n = 0; addr = 8'h10; dq_i = 16'h1234;
    #1;
    chk("R4 write floats bus", dq_oe, 0);
    chk("R12 wait write", wait_o, 0);
    next_cyc();
    we_n = 1;
    #1;
    chk("R3 output disable floats", dq_oe, 0);
    next_cyc();
    ce_n = 1; we_n = 0; addr = 8'h11; dq_i = 16'hBEEF;
    #1;
    chk("R2 standby floats", dq_oe, 0);
    next_cyc();
    we_n = 1; ce_n = 0; oe_n = 0; sync_mode = 0; addr = 8'h10;
    #1;
    chk("R4 written word", dq_o, 16'h1234);
    addr = 8'h11;
    #1;
    chk("R2 standby write ignored", dq_o, init_word(8'h11));
    next_cyc();
    idle_pins();
  endtask

  // Start a burst: the latching edge falls inside this call
  task automatic start_burst(input logic [AW-1:0] a, input logic [1:0] len);
    next_cyc();
    ce_n = 0; oe_n = 0; we_n = 1; sync_mode = 1; bclk_run = 1;
    adv_n = 0; addr = a; burst_len = len;
    next_cyc();
    adv_n = 1;
  endtask

  task automatic t_fixed(input logic [AW-1:0] a, input logic [1:0] len, input int n, input bit poke_adv);
    int mask;
    mask = n - 1;
    start_burst(a, len);
    for (int k = 0; k < n; k++) begin
      int exp_a;
      exp_a = (int'(a) & ~mask) | ((int'(a) + k) & mask);
      chk("R8 fixed burst word", dq_o, init_word(exp_a));
      chk("R8 fixed no wait", wait_o, 0);
      if (poke_adv && k == 1) begin adv_n = 0; addr = 8'h55; end
      if (poke_adv && k == 3) begin adv_n = 1; addr = 8'h00; end
      next_cyc();
    end
    chk("R8 idle after burst", dq_o, 0);
    chk("R8 bus driven after burst", dq_oe, 1);
    idle_pins();
  endtask

  task automatic t_continuous();
    start_burst(8'h1D, 2'b11);
    chk("R7 first word", dq_o, init_word(8'h1D)); next_cyc();
    chk("R9 linear", dq_o, init_word(8'h1E)); next_cyc();
    chk("R9 group end", dq_o, init_word(8'h1F));
    chk("R9 no wait yet", wait_o, 0); next_cyc();
    chk("R9 wait held word", dq_o, init_word(8'h1F));
    chk("R9 wait asserted", wait_o, 1); next_cyc();
    chk("R9 after refetch", dq_o, init_word(8'h20));
    chk("R9 wait released", wait_o, 0); next_cyc();
    chk("R9 continues", dq_o, init_word(8'h21));
    idle_pins();
  endtask

  task automatic t_suspend();
    start_burst(8'h40, 2'b11);
    chk("R7 start word", dq_o, init_word(8'h40)); next_cyc();
    chk("R10 before suspend", dq_o, init_word(8'h41));
    bclk_run = 0;
    for (int k = 0; k < 3; k++) begin
      next_cyc();
      chk("R10 held word", dq_o, init_word(8'h41));
      chk("R10 bus driven", dq_oe, 1);
      chk("R10 wait low", wait_o, 0);
    end
    bclk_run = 1;
    next_cyc();
    chk("R10 resumed", dq_o, init_word(8'h42));
    idle_pins();
  endtask

  task automatic t_terminate();
    start_burst(8'h80, 2'b11);
    chk("R11 first word", dq_o, init_word(8'h80));
    oe_n = 1;
    #1;
    chk("R11 oe high floats", dq_oe, 0);
    next_cyc();
    oe_n = 0;
    #1;
    chk("R11 burst ended", dq_o, 0);
    next_cyc();
    chk("R11 stays idle", dq_o, 0);
    idle_pins();
  endtask

  initial begin
    t_reset();
    t_async_read();
    t_write_standby();
    t_fixed(8'h06, 2'b00, 4, 0);
    t_fixed(8'h0D, 2'b01, 8, 1);
    t_fixed(8'h23, 2'b10, 16, 0);
    t_continuous();
    t_suspend();
    t_terminate();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule